// File: doc/BRIEF.md
# Multi-Queue In-Order Execution Unit

This block is one execution unit in a machine where a central steering stage spreads instructions over many simple units. The unit holds several small first-in-first-out instruction queues. Each queue is meant to hold one chain of dependent instructions. Only the head of a queue may start. At most one head starts per clock, and when several heads could start, the one with the oldest global sequence number wins. An instruction stays in its queue until its result comes out of the pipelined integer datapath.

Operands that are not yet known at dispatch carry the sequence number of their producer as a tag. They are captured from a forwarding bus when a matching tag appears. Consumer units that depend on an instruction register themselves after dispatch, by sending the producer's sequence number and their own unit number. Each registration sets one bit in that entry's destination mask. The mask leaves with the result. A registration that arrives one cycle after the result left is served from a one-cycle holding register on a separate late-delivery port. The unit reports, every cycle, which queues are empty and which are full, for the steering stage.

Top module: `eu_exec_unit`

## Requirements
- R1: The opcode field selects the result as follows: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a XOR b. All arithmetic wraps modulo 2^DW.
- R2: A dispatch with both operands ready, made into an empty queue while no other head is ready, produces out_valid with its sequence number and result exactly 1+LAT cycles after the dispatch cycle (3 with default parameters).
- R3: At most one instruction starts per cycle. Among ready heads, the oldest sequence number goes first. Age is judged modulo 2^SW, so x is older than y when (x-y) mod 2^SW has its top bit set. For example, 8'hFE is older than 8'h01.
- R4: A head that is waiting for an operand blocks only its own queue. A ready head in another queue starts and completes meanwhile.
- R5: Within a queue, instructions start in order. An entry behind a waiting head does not start. The next entry of a queue starts only after the previous one has completed, so its result follows LAT+1 cycles after the previous result.
- R6: A waiting operand whose tag equals fwd_tag while fwd_valid is high takes fwd_data. This applies to both operand slots.
- R7: reg_valid with reg_seq equal to a queued instruction's sequence number sets bit reg_unit of that entry's mask, and out_mask carries every registered bit. A registration in the completion cycle itself (reg_seq equal to out_seq) is included in out_mask in that same cycle.
- R8: In the cycle right after a completion, a registration whose reg_seq equals the completed sequence number raises late_valid, with late_seq, late_data and a one-hot late_mask for reg_unit. One cycle later the same registration raises nothing.
- R9: A queue holds DEPTH entries. A dispatch to a full queue is ignored and leaves the queued entries and their order untouched.
- R10: After reset all queues are empty and none is full, and out_valid and late_valid are low. q_empty[i] and q_full[i] track queue i every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch strobe |
| disp_q | input | QW | Target queue |
| disp_op | input | 2 | Opcode (R1) |
| disp_seq | input | SW | Global sequence number |
| disp_a_rdy | input | 1 | Operand a is known |
| disp_a_val | input | DW | Operand a value |
| disp_a_tag | input | SW | Producer sequence number of operand a |
| disp_b_rdy | input | 1 | Operand b is known |
| disp_b_val | input | DW | Operand b value |
| disp_b_tag | input | SW | Producer sequence number of operand b |
| fwd_valid | input | 1 | Forwarded operand strobe |
| fwd_tag | input | SW | Sequence number of the forwarded value |
| fwd_data | input | DW | Forwarded value |
| reg_valid | input | 1 | Consumer registration strobe |
| reg_seq | input | SW | Producer sequence number being registered against |
| reg_unit | input | UW | Registering consumer unit |
| out_valid | output | 1 | Result completes this cycle |
| out_seq | output | SW | Sequence number of the result |
| out_data | output | DW | Result value |
| out_mask | output | NU | Destination units of the result |
| late_valid | output | 1 | Late delivery from the holding register |
| late_seq | output | SW | Sequence number of the late result |
| late_data | output | DW | Late result value |
| late_mask | output | NU | One-hot late destination |
| q_empty | output | NQ | Per-queue empty flags |
| q_full | output | NQ | Per-queue full flags |

## Verification
The bench releases two waiting heads with one forward so that both become ready in the same cycle. It does this once with plain sequence numbers and once across the wrap point. A selector that compared raw numbers would send 8'h01 ahead of 8'hFE. It places a ready entry behind a waiting head and measures the spacing between the two results, which exposes a queue that lets its second entry start early, or restarts before a pop. Registrations are sent before completion, in the completion cycle and one and two cycles after it. A missing merge shows up as a lost mask bit, and a holding register kept too long shows up as a stale late delivery. A seventeenth dispatch into a full queue would overwrite the head, which changes the count and order of the drained results.

// File: rtl/eu_pkg.sv
package eu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_XOR = 2'd3
   } eu_op_e;
endpackage

// File: rtl/eu_iq_fifo.sv
module eu_iq_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 16,
   parameter int SW    = 8,
   parameter int NU    = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [1:0]    in_op,
   input  logic [SW-1:0] in_seq,
   input  logic          in_a_rdy,
   input  logic [DW-1:0] in_a_val,
   input  logic [SW-1:0] in_a_tag,
   input  logic          in_b_rdy,
   input  logic [DW-1:0] in_b_val,
   input  logic [SW-1:0] in_b_tag,
   input  logic          pop,
   input  logic          issue,
   input  logic          fwd_valid,
   input  logic [SW-1:0] fwd_tag,
   input  logic [DW-1:0] fwd_data,
   input  logic          reg_valid,
   input  logic [SW-1:0] reg_seq,
   input  logic [NU-1:0] reg_oh,
   output logic          hd_ready,
   output logic [1:0]    hd_op,
   output logic [SW-1:0] hd_seq,
   output logic [DW-1:0] hd_a,
   output logic [DW-1:0] hd_b,
   output logic [NU-1:0] hd_mask,
   output logic          empty,
   output logic          full
);
   logic [1:0]    op_m    [DEPTH];
   logic [SW-1:0] seq_m   [DEPTH];
   logic          a_rdy_m [DEPTH];
   logic          b_rdy_m [DEPTH];
   logic [DW-1:0] a_val_m [DEPTH];
   logic [DW-1:0] b_val_m [DEPTH];
   logic [SW-1:0] a_tag_m [DEPTH];
   logic [SW-1:0] b_tag_m [DEPTH];
   logic [NU-1:0] mask_m  [DEPTH];

   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [PW:0]   cnt;
   logic          issued;
   logic          push_ok;
   logic          a_hit_in, b_hit_in;

   assign push_ok  = push && !full;
   assign a_hit_in = fwd_valid && (in_a_tag == fwd_tag);
   assign b_hit_in = fwd_valid && (in_b_tag == fwd_tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
         issued <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            op_m[i]    <= '0;
            seq_m[i]   <= '0;
            a_rdy_m[i] <= 1'b0;
            b_rdy_m[i] <= 1'b0;
            a_val_m[i] <= '0;
            b_val_m[i] <= '0;
            a_tag_m[i] <= '0;
            b_tag_m[i] <= '0;
            mask_m[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (fwd_valid && !a_rdy_m[i] && (a_tag_m[i] == fwd_tag)) begin
               a_rdy_m[i] <= 1'b1;
               a_val_m[i] <= fwd_data;
            end
            if (fwd_valid && !b_rdy_m[i] && (b_tag_m[i] == fwd_tag)) begin
               b_rdy_m[i] <= 1'b1;
               b_val_m[i] <= fwd_data;
            end
            if (reg_valid && (seq_m[i] == reg_seq))
               mask_m[i] <= mask_m[i] | reg_oh;
         end
         if (push_ok) begin
            op_m[wr_ptr]    <= in_op;
            seq_m[wr_ptr]   <= in_seq;
            a_rdy_m[wr_ptr] <= in_a_rdy | a_hit_in;
            b_rdy_m[wr_ptr] <= in_b_rdy | b_hit_in;
            a_val_m[wr_ptr] <= in_a_rdy ? in_a_val : fwd_data;
            b_val_m[wr_ptr] <= in_b_rdy ? in_b_val : fwd_data;
            a_tag_m[wr_ptr] <= in_a_tag;
            b_tag_m[wr_ptr] <= in_b_tag;
            mask_m[wr_ptr]  <= '0;
            wr_ptr          <= wr_ptr + PW'(1);
         end
         if (pop) begin
            rd_ptr <= rd_ptr + PW'(1);
            issued <= 1'b0;
         end else if (issue) begin
            issued <= 1'b1;
         end
         case ({push_ok, pop})
            2'b10:   cnt <= cnt + (PW+1)'(1);
            2'b01:   cnt <= cnt - (PW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign empty    = (cnt == '0);
   assign full     = (cnt == (PW+1)'(DEPTH));
   assign hd_ready = !empty && !issued && a_rdy_m[rd_ptr] && b_rdy_m[rd_ptr];
   assign hd_op    = op_m[rd_ptr];
   assign hd_seq   = seq_m[rd_ptr];
   assign hd_a     = a_val_m[rd_ptr];
   assign hd_b     = b_val_m[rd_ptr];
   assign hd_mask  = mask_m[rd_ptr];
endmodule

// File: rtl/eu_oldest_pick.sv
module eu_oldest_pick #(
   parameter int NQ = 4,
   parameter int SW = 8
) (
   input  logic [NQ-1:0]    req,
   input  logic [NQ*SW-1:0] seq_flat,
   output logic [NQ-1:0]    grant
);
   function automatic logic is_older(input logic [SW-1:0] x, input logic [SW-1:0] y);
      logic [SW-1:0] d;
      d = x - y;
      return d[SW-1];
   endfunction

   always_comb begin
      logic [SW-1:0] si, sj;
      for (int i = 0; i < NQ; i++) begin
         grant[i] = req[i];
         si = seq_flat[i*SW +: SW];
         for (int j = 0; j < NQ; j++) begin
            sj = seq_flat[j*SW +: SW];
            if (j != i && req[j]) begin
               if (!(is_older(si, sj) || ((si == sj) && (i < j))))
                  grant[i] = 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/eu_exec_pipe.sv
module eu_exec_pipe
   import eu_pkg::*;
#(
   parameter int DW  = 16,
   parameter int SW  = 8,
   parameter int QW  = 2,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    in_op,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   input  logic [SW-1:0] in_seq,
   input  logic [QW-1:0] in_q,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [SW-1:0] out_seq,
   output logic [QW-1:0] out_q
);
   logic [DW-1:0] alu;
   logic          st_v [LAT];
   logic [DW-1:0] st_d [LAT];
   logic [SW-1:0] st_s [LAT];
   logic [QW-1:0] st_q [LAT];

   always_comb begin
      case (eu_op_e'(in_op))
         OP_ADD:  alu = in_a + in_b;
         OP_SUB:  alu = in_a - in_b;
         OP_AND:  alu = in_a & in_b;
         default: alu = in_a ^ in_b;
      endcase
   end

   for (genvar k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[0] <= 1'b0;
               st_d[0] <= '0;
               st_s[0] <= '0;
               st_q[0] <= '0;
            end else begin
               st_v[0] <= in_valid;
               st_d[0] <= alu;
               st_s[0] <= in_seq;
               st_q[0] <= in_q;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_v[k] <= 1'b0;
               st_d[k] <= '0;
               st_s[k] <= '0;
               st_q[k] <= '0;
            end else begin
               st_v[k] <= st_v[k-1];
               st_d[k] <= st_d[k-1];
               st_s[k] <= st_s[k-1];
               st_q[k] <= st_q[k-1];
            end
         end
      end
   end

   assign out_valid = st_v[LAT-1];
   assign out_data  = st_d[LAT-1];
   assign out_seq   = st_s[LAT-1];
   assign out_q     = st_q[LAT-1];
endmodule

// File: rtl/eu_exec_unit.sv
module eu_exec_unit #(
   parameter int NQ    = 4,
   parameter int DEPTH = 16,
   parameter int DW    = 16,
   parameter int SW    = 8,
   parameter int NU    = 8,
   parameter int LAT   = 2,
   localparam int QW   = $clog2(NQ),
   localparam int UW   = $clog2(NU)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_valid,
   input  logic [QW-1:0] disp_q,
   input  logic [1:0]    disp_op,
   input  logic [SW-1:0] disp_seq,
   input  logic          disp_a_rdy,
   input  logic [DW-1:0] disp_a_val,
   input  logic [SW-1:0] disp_a_tag,
   input  logic          disp_b_rdy,
   input  logic [DW-1:0] disp_b_val,
   input  logic [SW-1:0] disp_b_tag,
   input  logic          fwd_valid,
   input  logic [SW-1:0] fwd_tag,
   input  logic [DW-1:0] fwd_data,
   input  logic          reg_valid,
   input  logic [SW-1:0] reg_seq,
   input  logic [UW-1:0] reg_unit,
   output logic          out_valid,
   output logic [SW-1:0] out_seq,
   output logic [DW-1:0] out_data,
   output logic [NU-1:0] out_mask,
   output logic          late_valid,
   output logic [SW-1:0] late_seq,
   output logic [DW-1:0] late_data,
   output logic [NU-1:0] late_mask,
   output logic [NQ-1:0] q_empty,
   output logic [NQ-1:0] q_full
);
   if (NQ < 2 || NQ != (1 << QW)) begin : g_bad_nq
      $error("NQ must be a power of two of at least 2");
   end
   if (DEPTH < 2 || DEPTH != (1 << $clog2(DEPTH))) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (NU < 2 || NU != (1 << UW)) begin : g_bad_nu
      $error("NU must be a power of two of at least 2");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end

   logic [NQ-1:0]    hd_ready, grant, push_v, pop_v;
   logic [1:0]       hd_op   [NQ];
   logic [SW-1:0]    hd_seq  [NQ];
   logic [DW-1:0]    hd_a    [NQ];
   logic [DW-1:0]    hd_b    [NQ];
   logic [NU-1:0]    hd_mask [NQ];
   logic [NQ*SW-1:0] seq_flat;
   logic [NU-1:0]    reg_oh;

   logic          issue_valid;
   logic [QW-1:0] issue_q;
   logic          p_valid;
   logic [DW-1:0] p_data;
   logic [SW-1:0] p_seq;
   logic [QW-1:0] p_q;
   logic          hold_valid;
   logic [SW-1:0] hold_seq;
   logic [DW-1:0] hold_data;

   assign reg_oh = {{(NU-1){1'b0}}, 1'b1} << reg_unit;

   for (genvar g = 0; g < NQ; g++) begin : g_queue
      assign push_v[g] = disp_valid && (disp_q == QW'(g));
      assign pop_v[g]  = p_valid && (p_q == QW'(g));
      assign seq_flat[g*SW +: SW] = hd_seq[g];

      eu_iq_fifo #(
         .DEPTH(DEPTH), .DW(DW), .SW(SW), .NU(NU)
      ) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push_v[g]),
         .in_op     (disp_op),
         .in_seq    (disp_seq),
         .in_a_rdy  (disp_a_rdy),
         .in_a_val  (disp_a_val),
         .in_a_tag  (disp_a_tag),
         .in_b_rdy  (disp_b_rdy),
         .in_b_val  (disp_b_val),
         .in_b_tag  (disp_b_tag),
         .pop       (pop_v[g]),
         .issue     (grant[g]),
         .fwd_valid (fwd_valid),
         .fwd_tag   (fwd_tag),
         .fwd_data  (fwd_data),
         .reg_valid (reg_valid),
         .reg_seq   (reg_seq),
         .reg_oh    (reg_oh),
         .hd_ready  (hd_ready[g]),
         .hd_op     (hd_op[g]),
         .hd_seq    (hd_seq[g]),
         .hd_a      (hd_a[g]),
         .hd_b      (hd_b[g]),
         .hd_mask   (hd_mask[g]),
         .empty     (q_empty[g]),
         .full      (q_full[g])
      );
   end

   eu_oldest_pick #(.NQ(NQ), .SW(SW)) u_pick (
      .req      (hd_ready),
      .seq_flat (seq_flat),
      .grant    (grant)
   );

   always_comb begin
      issue_valid = 1'b0;
      issue_q     = '0;
      for (int i = 0; i < NQ; i++) begin
         if (grant[i]) begin
            issue_valid = 1'b1;
            issue_q     = QW'(i);
         end
      end
   end

   eu_exec_pipe #(.DW(DW), .SW(SW), .QW(QW), .LAT(LAT)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (issue_valid),
      .in_op     (hd_op[issue_q]),
      .in_a      (hd_a[issue_q]),
      .in_b      (hd_b[issue_q]),
      .in_seq    (hd_seq[issue_q]),
      .in_q      (issue_q),
      .out_valid (p_valid),
      .out_data  (p_data),
      .out_seq   (p_seq),
      .out_q     (p_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_seq   <= '0;
         hold_data  <= '0;
      end else begin
         hold_valid <= p_valid;
         hold_seq   <= p_seq;
         hold_data  <= p_data;
      end
   end

   assign out_valid  = p_valid;
   assign out_seq    = p_seq;
   assign out_data   = p_data;
   assign out_mask   = p_valid ? (hd_mask[p_q] |
                        ((reg_valid && reg_seq == p_seq) ? reg_oh : '0)) : '0;
   assign late_valid = hold_valid && reg_valid && (reg_seq == hold_seq);
   assign late_seq   = hold_seq;
   assign late_data  = hold_data;
   assign late_mask  = late_valid ? reg_oh : '0;
endmodule

// File: rtl/eu_exec_unit_chk.sv
module eu_exec_unit_chk #(
   parameter int NQ = 4,
   parameter int SW = 8,
   parameter int NU = 8,
   localparam int QW = $clog2(NQ),
   localparam int UW = $clog2(NU)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NQ-1:0] grant,
   input logic          issue_valid,
   input logic [QW-1:0] issue_q,
   input logic [NQ-1:0] q_empty,
   input logic [NQ-1:0] q_full,
   input logic          out_valid,
   input logic [SW-1:0] out_seq,
   input logic [NU-1:0] out_mask,
   input logic          reg_valid,
   input logic [SW-1:0] reg_seq,
   input logic [UW-1:0] reg_unit,
   input logic          late_valid
);
   AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R3

   AST_ISSUE_FROM_LIVE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !q_empty[issue_q]); // R5

   AST_REG_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && reg_valid && reg_seq == out_seq) |-> out_mask[reg_unit]); // R7

   AST_LATE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      late_valid |-> $past(out_valid)); // R8

   for (genvar g = 0; g < NQ; g++) begin : g_full
      AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (q_full[g] && !out_valid) |=> q_full[g]); // R9
      AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         !(q_full[g] && q_empty[g])); // R10
   end
endmodule

bind eu_exec_unit eu_exec_unit_chk #(.NQ(NQ), .SW(SW), .NU(NU)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .grant       (grant),
   .issue_valid (issue_valid),
   .issue_q     (issue_q),
   .q_empty     (q_empty),
   .q_full      (q_full),
   .out_valid   (out_valid),
   .out_seq     (out_seq),
   .out_mask    (out_mask),
   .reg_valid   (reg_valid),
   .reg_seq     (reg_seq),
   .reg_unit    (reg_unit),
   .late_valid  (late_valid)
);

// File: tb/eu_exec_unit_bench.sv
module eu_exec_unit_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        disp_valid;
   logic [1:0]  disp_q;
   logic [1:0]  disp_op;
   logic [7:0]  disp_seq;
   logic        disp_a_rdy, disp_b_rdy;
   logic [15:0] disp_a_val, disp_b_val;
   logic [7:0]  disp_a_tag, disp_b_tag;
   logic        fwd_valid;
   logic [7:0]  fwd_tag;
   logic [15:0] fwd_data;
   logic        reg_valid;
   logic [7:0]  reg_seq;
   logic [2:0]  reg_unit;
   logic        out_valid, late_valid;
   logic [7:0]  out_seq, late_seq;
   logic [15:0] out_data, late_data;
   logic [7:0]  out_mask, late_mask;
   logic [3:0]  q_empty, q_full;

   int errors = 0;
   int checks = 0;

   always #(CLK_P/2) clk = ~clk;

   eu_exec_unit u_eu_exec_unit (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_q(disp_q), .disp_op(disp_op), .disp_seq(disp_seq),
      .disp_a_rdy(disp_a_rdy), .disp_a_val(disp_a_val), .disp_a_tag(disp_a_tag),
      .disp_b_rdy(disp_b_rdy), .disp_b_val(disp_b_val), .disp_b_tag(disp_b_tag),
      .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
      .reg_valid(reg_valid), .reg_seq(reg_seq), .reg_unit(reg_unit),
      .out_valid(out_valid), .out_seq(out_seq), .out_data(out_data), .out_mask(out_mask),
      .late_valid(late_valid), .late_seq(late_seq), .late_data(late_data), .late_mask(late_mask),
      .q_empty(q_empty), .q_full(q_full)
   );

   // op, a, b, expected result
   localparam logic [49:0] VEC [8] = '{
      {2'd0, 16'h1234, 16'h0101, 16'h1335},
      {2'd0, 16'hFFFF, 16'h0002, 16'h0001},
      {2'd1, 16'h0005, 16'h0007, 16'hFFFE},
      {2'd1, 16'h8000, 16'h0001, 16'h7FFF},
      {2'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
      {2'd2, 16'hFFFF, 16'h0000, 16'h0000},
      {2'd3, 16'hAAAA, 16'h5555, 16'hFFFF},
      {2'd3, 16'h1234, 16'h1234, 16'h0000}
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic dispatch(input int q, input logic [1:0] op, input logic [7:0] seq,
                           input logic ar, input logic [15:0] av, input logic [7:0] at,
                           input logic br, input logic [15:0] bv, input logic [7:0] bt);
      disp_valid = 1'b1; disp_q = 2'(q); disp_op = op; disp_seq = seq;
      disp_a_rdy = ar; disp_a_val = av; disp_a_tag = at;
      disp_b_rdy = br; disp_b_val = bv; disp_b_tag = bt;
      @(negedge clk);
      disp_valid = 1'b0;
   endtask

   task automatic send_fwd(input logic [7:0] tag, input logic [15:0] data);
      fwd_valid = 1'b1; fwd_tag = tag; fwd_data = data;
      @(negedge clk);
      fwd_valid = 1'b0;
   endtask

   task automatic send_reg(input logic [7:0] seq, input logic [2:0] unit);
      reg_valid = 1'b1; reg_seq = seq; reg_unit = unit;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic wait_out(input int limit, output bit got);
      got = 1'b0;
      for (int k = 0; k < limit && !got; k++) begin
         if (out_valid) got = 1'b1;
         else @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit got;
      int n_out;
      logic [7:0] last;
      bit saw_bad;
      rst_n = 1'b0;
      disp_valid = 0; disp_q = 0; disp_op = 0; disp_seq = 0;
      disp_a_rdy = 0; disp_a_val = 0; disp_a_tag = 0;
      disp_b_rdy = 0; disp_b_val = 0; disp_b_tag = 0;
      fwd_valid = 0; fwd_tag = 0; fwd_data = 0;
      reg_valid = 0; reg_seq = 0; reg_unit = 0;
      repeat (3) @(negedge clk);
      chk("R10 reset empty", 32'(q_empty), 32'hF);
      chk("R10 reset full", 32'(q_full), 32'h0);
      chk("R10 reset out_valid", 32'(out_valid), 32'h0);
      chk("R10 reset late_valid", 32'(late_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: table walk with exact latency
      for (int v = 0; v < 8; v++) begin
         dispatch(v % 4, VEC[v][49:48], 8'h10 + 8'(v), 1'b1, VEC[v][47:32], 8'h00,
                  1'b1, VEC[v][31:16], 8'h00);
         chk("R2 no early result", 32'(out_valid), 32'h0);
         @(negedge clk);
         chk("R2 no early result", 32'(out_valid), 32'h0);
         @(negedge clk);
         chk("R2 result on time", 32'(out_valid), 32'h1);
         chk("R2 result seq", 32'(out_seq), 32'(8'h10 + 8'(v)));
         chk("R1 result value", 32'(out_data), 32'(VEC[v][15:0]));
         chk("R7 empty mask", 32'(out_mask), 32'h0);
         @(negedge clk);
      end

      // R3 / R6: two heads released together, oldest first
      dispatch(0, 2'd0, 8'h40, 1'b0, 16'h0, 8'h77, 1'b1, 16'h0001, 8'h00);
      dispatch(1, 2'd0, 8'h3F, 1'b0, 16'h0, 8'h77, 1'b1, 16'h0001, 8'h00);
      send_fwd(8'h77, 16'h0005);
      wait_out(10, got);
      chk("R3 oldest first", 32'(out_seq), 32'h3F);
      chk("R6 forwarded operand", 32'(out_data), 32'h0006);
      @(negedge clk);
      chk("R3 second next cycle", 32'({out_valid, out_seq}), 32'h140);

      // R3: wraparound age
      @(negedge clk);
      dispatch(3, 2'd0, 8'h01, 1'b0, 16'h0, 8'h78, 1'b1, 16'h0001, 8'h00);
      dispatch(2, 2'd0, 8'hFE, 1'b0, 16'h0, 8'h78, 1'b1, 16'h0001, 8'h00);
      send_fwd(8'h78, 16'h0002);
      wait_out(10, got);
      chk("R3 wrap oldest first", 32'(out_seq), 32'hFE);
      @(negedge clk);
      chk("R3 wrap second", 32'({out_valid, out_seq}), 32'h101);

      // R4: waiting head does not block another queue
      @(negedge clk);
      dispatch(0, 2'd0, 8'h50, 1'b0, 16'h0, 8'h79, 1'b1, 16'h0001, 8'h00);
      dispatch(1, 2'd0, 8'h51, 1'b1, 16'h0003, 8'h00, 1'b1, 16'h0004, 8'h00);
      wait_out(10, got);
      chk("R4 other queue completes", 32'({got, out_seq, out_data}), {7'd0, 1'b1, 8'h51, 16'h0007});
      chk("R4 blocked queue still holds", 32'(q_empty[0]), 32'h0);
      send_fwd(8'h79, 16'h0009);
      wait_out(10, got);
      chk("R4 blocked head completes later", 32'({got, out_seq, out_data}), {7'd0, 1'b1, 8'h50, 16'h000A});
      @(negedge clk);

      // R5: entry behind a waiting head stays put
      dispatch(2, 2'd0, 8'h60, 1'b0, 16'h0, 8'h7A, 1'b1, 16'h0001, 8'h00);
      dispatch(2, 2'd3, 8'h61, 1'b1, 16'h00F0, 8'h00, 1'b1, 16'h000F, 8'h00);
      saw_bad = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (out_valid) saw_bad = 1'b1;
         @(negedge clk);
      end
      chk("R5 no start behind waiting head", 32'(saw_bad), 32'h0);
      send_fwd(8'h7A, 16'h0001);
      wait_out(10, got);
      chk("R5 head first", 32'(out_seq), 32'h60);
      @(negedge clk);
      chk("R5 no overlap", 32'(out_valid), 32'h0);
      @(negedge clk);
      chk("R5 no overlap", 32'(out_valid), 32'h0);
      @(negedge clk);
      chk("R5 follower after completion", 32'({out_valid, out_seq, out_data}),
          {7'd0, 1'b1, 8'h61, 16'h00FF});
      @(negedge clk);

      // R7 / R6: registrations before completion, both operands forwarded
      dispatch(0, 2'd0, 8'h70, 1'b0, 16'h0, 8'h7B, 1'b0, 16'h0, 8'h7B);
      send_reg(8'h70, 3'd3);
      send_reg(8'h70, 3'd5);
      send_fwd(8'h7B, 16'h0010);
      wait_out(10, got);
      chk("R7 registered mask", 32'(out_mask), 32'h28);
      chk("R6 both operands captured", 32'(out_data), 32'h0020);
      @(negedge clk);

      // R7: registration in completion cycle
      dispatch(1, 2'd0, 8'h71, 1'b1, 16'h0001, 8'h00, 1'b1, 16'h0001, 8'h00);
      @(negedge clk);
      @(negedge clk);
      reg_valid = 1'b1; reg_seq = 8'h71; reg_unit = 3'd6;
      #1;
      chk("R7 same-cycle merge", 32'({out_valid, out_mask}), 32'h140);
      chk("R8 no late in completion cycle", 32'(late_valid), 32'h0);
      @(negedge clk);
      reg_valid = 1'b0;

      // R8: late registration served one cycle after completion only
      @(negedge clk);
      dispatch(2, 2'd1, 8'h72, 1'b1, 16'h0009, 8'h00, 1'b1, 16'h0001, 8'h00);
      @(negedge clk);
      @(negedge clk);
      chk("R8 completion mask", 32'({out_valid, out_mask}), 32'h100);
      @(negedge clk);
      reg_valid = 1'b1; reg_seq = 8'h72; reg_unit = 3'd2;
      #1;
      chk("R8 late delivery", 32'({late_valid, late_seq, late_data}), {7'd0, 1'b1, 8'h72, 16'h0008});
      chk("R8 late mask", 32'(late_mask), 32'h04);
      @(negedge clk);
      reg_unit = 3'd1;
      #1;
      chk("R8 holding expires", 32'(late_valid), 32'h0);
      @(negedge clk);
      reg_valid = 1'b0;

      // R9 / R10: fill a queue, overflow dispatch ignored
      repeat (2) @(negedge clk);
      chk("R10 all empty", 32'(q_empty), 32'hF);
      for (int k = 0; k < 16; k++)
         dispatch(3, 2'd0, 8'h80 + 8'(k), 1'b0, 16'h0, 8'h7C, 1'b1, 16'h0001, 8'h00);
      chk("R10 full flag", 32'(q_full), 32'h8);
      dispatch(3, 2'd0, 8'h99, 1'b1, 16'h0, 8'h00, 1'b1, 16'h0001, 8'h00);
      chk("R9 still full after overflow", 32'(q_full), 32'h8);
      chk("R9 overflow not started", 32'(out_valid), 32'h0);
      send_fwd(8'h7C, 16'h0100);
      n_out = 0; last = 8'h00; saw_bad = 1'b0;
      for (int k = 0; k < 80; k++) begin
         if (out_valid) begin
            if (out_seq != 8'h80 + 8'(n_out)) saw_bad = 1'b1;
            n_out++;
            last = out_seq;
         end
         @(negedge clk);
      end
      chk("R9 drained count", 32'(n_out), 32'd16);
      chk("R9 drained order", 32'(saw_bad), 32'h0);
      chk("R9 last drained", 32'(last), 32'h8F);
      chk("R10 empty after drain", 32'(q_empty), 32'hF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule